// File: doc/BRIEF.md
# TDM Time-Slot Routing Sequencer

This block splits a serial time-division-multiplexed frame into per-channel bit streams and merges them back. It does not count fixed slots. It walks a short table of routing entries. Each entry names a destination channel, a run length counted in bits or bytes, and a flag that marks the end of the frame. Two independent tables are held: one routes received bits and one picks the source of transmitted bits. Software fills both through a simple synchronous write port.

On the receive side, each sampled bit is presented to the channel that owns the current entry, together with a one-cycle strobe. A reserved channel code diverts bits to a grant latch instead of a data channel. The latch keeps the last bit sampled under that code, so a controller can use it as a transmit grant. On the transmit side, the block chooses which channel's bit goes out. The line is open-drain: the block can only pull it low or release it.

The serial clock edges arrive as single-cycle enables on the system clock (`sclk_rise`, `sclk_fall`). A frame sync is sampled on a rising enable and takes up one bit period of its own. The first frame bit is driven on the next falling enable and sampled on the next rising enable.

Top module: `tdm_slot_router`

## Requirements
- R1: A write with `cfg_we` high sets table entry `cfg_addr[6:0]` of the receive table when `cfg_addr[7]` is 0, and of the transmit table when it is 1. A write to an index at or above the table depth changes nothing. A written entry is used only from the frame that starts at the next sync.
- R2: Entry word layout: bit 0 is the end-of-frame flag, bit 1 selects byte units, bits 5:2 hold the count, and bits 8:6 hold the channel code. An entry lasts (count+1) bits, or (count+1)×8 bits when byte units are selected.
- R3: For an entry with channel code 1 to 6, each rising enable samples `ser_rxd`. The cycle after the enable, `rx_strb[code-1]` pulses for one cycle and `rx_bit` holds the sampled value.
- R4: Channel code 0 skips its bits. It produces no receive strobe and no transmit take, and the transmit line stays released.
- R5: Channel code 7 produces no data strobe. Instead, `gnt_strb` pulses and `gnt_bit` takes the sampled bit. `gnt_bit` then keeps that value until the next code-7 bit, including across frames.
- R6: After the entry carrying the end-of-frame flag has finished, or after the last table index has finished, no channel is served until the next sync.
- R7: A rising enable with `fsync` high restarts both tables at entry 0, even in mid-frame. In that cycle no strobe is raised and the transmit line is released.
- R8: On each falling enable during a code 1 to 6 entry, `tx_take[code-1]` pulses for one cycle. `txd_pull_low` is then set to the inverse of `tx_data[code-1]` and holds until the next falling enable.
- R9: The transmit table is sequenced by falling enables and is independent of the receive table contents.
- R10: After reset, every entry of both tables holds 0x0001 and all outputs are low. Until the first sync, nothing is routed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_rise | input | 1 | One-cycle enable marking a rising serial clock edge |
| sclk_fall | input | 1 | One-cycle enable marking a falling serial clock edge |
| fsync | input | 1 | Frame sync, sampled with `sclk_rise` |
| ser_rxd | input | 1 | Serial receive data |
| rx_strb | output | 6 | Per-channel receive strobe, one-hot |
| rx_bit | output | 1 | Most recently sampled receive bit |
| gnt_strb | output | 1 | Pulse when a grant bit is sampled |
| gnt_bit | output | 1 | Held grant value |
| tx_data | input | 6 | Current transmit bit of each channel |
| tx_take | output | 6 | Pulse telling a channel its bit was consumed |
| txd_pull_low | output | 1 | 1 pulls the open-drain line low, 0 releases it |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 8 | Table write address |
| cfg_wdata | input | 16 | Table write data |

## Verification
The assertions assume that the two serial enables never fall in the same system cycle and that each pulse lasts exactly one cycle. They also assume that the active tables change only at a sync, which holds because writes go to a staging copy. The stimulus drives each enable in a separate task step, always with idle cycles between a rising and a falling enable. It raises `fsync` only together with `sclk_rise`. With those limits, the strobe-exclusivity and hold properties can treat each enable as one isolated bit event.

// File: rtl/tdm_rt_pkg.sv
`timescale 1ns/1ps
package tdm_rt_pkg;
  localparam int CSEL_W = 3;
  localparam int NUM_CH = (2 ** CSEL_W) - 2;
  localparam int SPAN_W = 7;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 16;

  localparam logic [CSEL_W-1:0] CSEL_SKIP   = '0;
  localparam logic [CSEL_W-1:0] CSEL_STROBE = '1;

  typedef struct packed {
    logic [CSEL_W-1:0] csel;
    logic [3:0]        cnt;
    logic              byte_u;
    logic              last;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);
  localparam entry_t ENTRY_IDLE = '{csel: '0, cnt: 4'd0, byte_u: 1'b0, last: 1'b1};

  // bit-periods covered by an entry, minus one
  function automatic logic [SPAN_W-1:0] entry_span(entry_t e);
    logic [SPAN_W-1:0] n;
    n = SPAN_W'(e.cnt);
    return e.byte_u ? ((n << 3) + SPAN_W'(7)) : n;
  endfunction

  function automatic logic is_data(logic [CSEL_W-1:0] c);
    return (c != CSEL_SKIP) && (c != CSEL_STROBE);
  endfunction
endpackage

// File: rtl/tdm_rt_tables.sv
`timescale 1ns/1ps
module tdm_rt_tables
  import tdm_rt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              load,
  output entry_t            rx_tbl [DEPTH],
  output entry_t            tx_tbl [DEPTH]
);
  localparam int NTBL = 2;

  entry_t shad [NTBL][DEPTH];
  entry_t act  [NTBL][DEPTH];
  entry_t wr_entry;

  always_comb wr_entry = entry_t'(wdata[ENTRY_W-1:0]);

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic hit;
      always_comb hit = we && (addr[ADDR_W-1] == 1'(t)) && (addr[ADDR_W-2:0] == (ADDR_W-1)'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   shad[t][i] <= ENTRY_IDLE;
        else if (hit) shad[t][i] <= wr_entry;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    act[t][i] <= ENTRY_IDLE;
        else if (load) act[t][i] <= shad[t][i];
      end
    end
  end

  assign rx_tbl = act[0];
  assign tx_tbl = act[1];
endmodule

// File: rtl/tdm_rt_seq.sv
`timescale 1ns/1ps
module tdm_rt_seq
  import tdm_rt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  entry_t            tbl [DEPTH],
  output logic [CSEL_W-1:0] cur_csel
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IW-1:0]     ptr_q, ptr_d;
  logic [SPAN_W-1:0] cnt_q, cnt_d;
  logic              done_q, done_d;
  entry_t            cur;
  logic [SPAN_W-1:0] span;

  always_comb begin
    cur    = tbl[ptr_q];
    span   = entry_span(cur);
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (restart) begin
      ptr_d  = '0;
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (step && !done_q) begin
      if (cnt_q == span) begin
        cnt_d = '0;
        if (cur.last || (ptr_q == IW'(DEPTH - 1))) done_d = 1'b1;
        else                                        ptr_d  = ptr_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else begin
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign cur_csel = done_q ? CSEL_SKIP : cur.csel;

  AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ptr_q == '0 && cnt_q == '0 && !done_q)); // R7
  AST_SEQ_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !restart) |=> done_q); // R6
  AST_SEQ_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> (cnt_q <= entry_span(tbl[ptr_q]))); // R2
endmodule

// File: rtl/tdm_rt_rx.sv
`timescale 1ns/1ps
module tdm_rt_rx
  import tdm_rt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CSEL_W-1:0] csel,
  input  logic              rxd,
  output logic [NUM_CH-1:0] strb,
  output logic              bit_o,
  output logic              gnt_strb,
  output logic              gnt_bit
);
  logic [NUM_CH-1:0] strb_d, strb_q;
  logic              bit_d, bit_q;
  logic              gs_d, gs_q;
  logic              gb_d, gb_q;
  logic [CSEL_W-1:0] idx;

  always_comb begin
    idx    = csel - 1'b1;
    strb_d = '0;
    bit_d  = bit_q;
    gs_d   = 1'b0;
    gb_d   = gb_q;
    if (en) begin
      bit_d = rxd;
      if (is_data(csel)) strb_d = NUM_CH'(1) << idx;
      if (csel == CSEL_STROBE) begin
        gs_d = 1'b1;
        gb_d = rxd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= '0;
      bit_q  <= 1'b0;
      gs_q   <= 1'b0;
      gb_q   <= 1'b0;
    end else begin
      strb_q <= strb_d;
      bit_q  <= bit_d;
      gs_q   <= gs_d;
      gb_q   <= gb_d;
    end
  end

  assign strb     = strb_q;
  assign bit_o    = bit_q;
  assign gnt_strb = gs_q;
  assign gnt_bit  = gb_q;

  AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb_q, gs_q})); // R3
  AST_RX_BIT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb_q) |-> (bit_q == $past(rxd))); // R3
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gs_q |-> $stable(gb_q)); // R5
endmodule

// File: rtl/tdm_rt_tx.sv
`timescale 1ns/1ps
module tdm_rt_tx
  import tdm_rt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic [CSEL_W-1:0] csel,
  input  logic [NUM_CH-1:0] tx_data,
  output logic [NUM_CH-1:0] take,
  output logic              pull_low
);
  logic [NUM_CH-1:0] take_d, take_q;
  logic              pull_d, pull_q;
  logic [CSEL_W-1:0] idx;

  always_comb begin
    idx    = csel - 1'b1;
    take_d = '0;
    pull_d = pull_q;
    if (clr) begin
      pull_d = 1'b0;
    end else if (en) begin
      if (is_data(csel)) begin
        take_d = NUM_CH'(1) << idx;
        pull_d = ~tx_data[idx];
      end else begin
        pull_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= '0;
      pull_q <= 1'b0;
    end else begin
      take_q <= take_d;
      pull_q <= pull_d;
    end
  end

  assign take     = take_q;
  assign pull_low = pull_q;

  AST_TX_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_q)); // R8
  AST_TX_PULL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> (|take_q)); // R8
  AST_TX_CLR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pull_q); // R7
endmodule

// File: rtl/tdm_slot_router.sv
`timescale 1ns/1ps
module tdm_slot_router
  import tdm_rt_pkg::*;
#(
  parameter int TBL_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              fsync,
  input  logic              ser_rxd,
  output logic [NUM_CH-1:0] rx_strb,
  output logic              rx_bit,
  output logic              gnt_strb,
  output logic              gnt_bit,
  input  logic [NUM_CH-1:0] tx_data,
  output logic [NUM_CH-1:0] tx_take,
  output logic              txd_pull_low,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata
);
  logic [1:0]        rst_pipe;
  logic              rst_i_n;
  logic              restart;
  logic              rx_en;
  logic [CSEL_W-1:0] rx_csel, tx_csel;
  entry_t            rx_tbl [TBL_DEPTH];
  entry_t            tx_tbl [TBL_DEPTH];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  always_comb begin
    restart = sclk_rise && fsync;
    rx_en   = sclk_rise && !fsync;
  end

  tdm_rt_tables #(.DEPTH(TBL_DEPTH)) u_tables (
    .clk(clk), .rst_n(rst_i_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(restart), .rx_tbl(rx_tbl), .tx_tbl(tx_tbl)
  );

  tdm_rt_seq #(.DEPTH(TBL_DEPTH)) u_rx_seq (
    .clk(clk), .rst_n(rst_i_n), .step(sclk_rise), .restart(restart),
    .tbl(rx_tbl), .cur_csel(rx_csel)
  );

  tdm_rt_seq #(.DEPTH(TBL_DEPTH)) u_tx_seq (
    .clk(clk), .rst_n(rst_i_n), .step(sclk_fall), .restart(restart),
    .tbl(tx_tbl), .cur_csel(tx_csel)
  );

  tdm_rt_rx u_rx (
    .clk(clk), .rst_n(rst_i_n), .en(rx_en), .csel(rx_csel), .rxd(ser_rxd),
    .strb(rx_strb), .bit_o(rx_bit), .gnt_strb(gnt_strb), .gnt_bit(gnt_bit)
  );

  tdm_rt_tx u_tx (
    .clk(clk), .rst_n(rst_i_n), .en(sclk_fall), .clr(restart), .csel(tx_csel),
    .tx_data(tx_data), .take(tx_take), .pull_low(txd_pull_low)
  );

  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    restart |=> (rx_strb == '0 && !gnt_strb && !txd_pull_low)); // R7
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rx_en && rx_csel == CSEL_SKIP) |=> (rx_strb == '0 && !gnt_strb)); // R4
endmodule

// File: tb/tdm_slot_router_tb_top.sv
`timescale 1ns/1ps
module tdm_slot_router_tb_top;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk_rise = 1'b0, sclk_fall = 1'b0, fsync = 1'b0, ser_rxd = 1'b0;
  logic [5:0] rx_strb, tx_take;
  logic       rx_bit, gnt_strb, gnt_bit, txd_pull_low;
  logic [5:0] tx_data = '0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;

  int checks = 0, fails = 0, pos = 0, seed = 0;
  logic exp_gnt = 1'b0;
  logic [15:0] rx_pend [DEPTH];
  logic [15:0] rx_act  [DEPTH];
  logic [15:0] tx_pend [DEPTH];
  logic [15:0] tx_act  [DEPTH];

  always #2.5 clk = ~clk;

  tdm_slot_router #(.TBL_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .fsync(fsync),
    .ser_rxd(ser_rxd), .rx_strb(rx_strb), .rx_bit(rx_bit), .gnt_strb(gnt_strb), .gnt_bit(gnt_bit),
    .tx_data(tx_data), .tx_take(tx_take), .txd_pull_low(txd_pull_low),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  function automatic logic [15:0] mk(int c, int n, bit b, bit l);
    return 16'((c << 6) | (n << 2) | (int'(b) << 1) | int'(l));
  endfunction

  function automatic int code_at(input logic [15:0] tb [DEPTH], input int p);
    int rem = p;
    for (int e = 0; e < DEPTH; e++) begin
      int len = (int'(tb[e][5:2]) + 1) * (tb[e][1] ? 8 : 1);
      if (rem < len) return int'(tb[e][8:6]);
      rem -= len;
      if (tb[e][0]) return 0;
    end
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if ((a % 128) < DEPTH) begin
      if (a < 128) rx_pend[a % 128] = d;
      else         tx_pend[a % 128] = d;
    end
  endtask

  task automatic sync_bit();
    @(negedge clk);
    fsync = 1'b1; sclk_rise = 1'b1; ser_rxd = 1'b1;
    @(negedge clk);
    fsync = 1'b0; sclk_rise = 1'b0;
    chk(rx_strb == 0 && !gnt_strb, "R7", "strobes at sync", int'({rx_strb, gnt_strb}), 0);
    chk(!txd_pull_low, "R7", "line at sync", int'(txd_pull_low), 0);
    rx_act = rx_pend; tx_act = tx_pend; pos = 0; seed++;
  endtask

  task automatic step_bit();
    int tc, rc;
    logic [5:0] td, et, er;
    logic rb, ep;
    tc = code_at(tx_act, pos);
    td = 6'((pos * 11 + 5) ^ 42);
    @(negedge clk);
    tx_data = td; sclk_fall = 1'b1;
    @(negedge clk);
    sclk_fall = 1'b0;
    et = (tc >= 1 && tc <= 6) ? 6'(1 << (tc - 1)) : 6'd0;
    ep = (tc >= 1 && tc <= 6) ? ~td[tc-1] : 1'b0;
    chk(tx_take == et, (tc >= 1 && tc <= 6) ? "R8,R9" : "R4,R6", "tx_take", int'(tx_take), int'(et));
    chk(txd_pull_low == ep, (tc >= 1 && tc <= 6) ? "R8,R2" : "R4,R6", "txd_pull_low", int'(txd_pull_low), int'(ep));

    rc = code_at(rx_act, pos);
    rb = ^(8'(pos * 13 + seed * 7));
    @(negedge clk);
    ser_rxd = rb; sclk_rise = 1'b1;
    @(negedge clk);
    sclk_rise = 1'b0;
    er = (rc >= 1 && rc <= 6) ? 6'(1 << (rc - 1)) : 6'd0;
    chk(rx_strb == er, (rc >= 1 && rc <= 6) ? "R2,R3" : "R4,R6", "rx_strb", int'(rx_strb), int'(er));
    if (er != 0) chk(rx_bit == rb, "R3", "rx_bit", int'(rx_bit), int'(rb));
    chk(gnt_strb == (rc == 7), "R5", "gnt_strb", int'(gnt_strb), int'(rc == 7));
    if (rc == 7) exp_gnt = rb;
    chk(gnt_bit == exp_gnt, "R5", "gnt_bit", int'(gnt_bit), int'(exp_gnt));
    pos++;
  endtask

  task automatic run_bits(input int n);
    for (int k = 0; k < n; k++) step_bit();
  endtask

  task automatic t_reset();
    chk(rx_strb == 0 && tx_take == 0 && !rx_bit && !gnt_strb && !gnt_bit && !txd_pull_low,
        "R10", "outputs after reset", int'({rx_strb, tx_take}), 0);
    run_bits(3);
    sync_bit();
    run_bits(4);
  endtask

  task automatic t_frame();
    wr(0, mk(1, 0, 1, 0)); wr(1, mk(2, 2, 0, 0)); wr(2, mk(7, 0, 0, 0));
    wr(3, mk(0, 1, 0, 0)); wr(4, mk(3, 0, 0, 1));
    wr(128, mk(2, 3, 0, 0)); wr(129, mk(0, 0, 0, 0)); wr(130, mk(7, 0, 0, 0));
    wr(131, mk(4, 1, 1, 1));
    sync_bit(); run_bits(26);
    sync_bit(); run_bits(24);
  endtask

  task automatic t_restart();
    sync_bit(); run_bits(5);
    sync_bit(); run_bits(12);
  endtask

  task automatic t_update();
    sync_bit(); run_bits(3);
    wr(0, mk(5, 1, 0, 0));
    wr(DEPTH, mk(6, 0, 0, 0));
    wr(128 + DEPTH, mk(6, 2, 0, 1));
    run_bits(6);
    sync_bit(); run_bits(20);
    chk(rx_pend[0] == mk(5, 1, 0, 0), "R1", "bench table", int'(rx_pend[0]), int'(mk(5, 1, 0, 0)));
  endtask

  task automatic t_full();
    for (int e = 0; e < DEPTH; e++) wr(e, mk(6, 0, 0, 0));
    sync_bit(); run_bits(DEPTH + 4);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    for (int e = 0; e < DEPTH; e++) begin
      rx_pend[e] = 16'h0001; tx_pend[e] = 16'h0001;
    end
    rx_act = rx_pend; tx_act = tx_pend;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_frame();
    t_restart();
    t_update();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule